// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block sits on the system side of a processor whose bus time-shares its pins. The low shared lines carry the address while the address-latch strobe is high and carry data once it has fallen. The upper shared lines carry the top address bits in the address phase and four status bits afterwards. The block rebuilds a stable 20-bit address from these lines. It captures and decodes the status nibble into a segment selector, the interrupt-enable state and a protocol-error flag. It gates read data onto the shared lines only while the read strobe is asserted. It also reports wait states when a slow device holds its ready line low.

Everything is synchronous to one clock, with an asynchronous active-low reset. The address output follows the lines directly while the strobe is high, so downstream decode sees it early. It holds the last value sampled with the strobe high for the rest of the bus cycle, including any number of wait states. Status is registered on the first clock edge that sees the strobe low after it was high. It stays put until the next address phase begins.

Top module: `adbus_demux`

## Requirements
- R1: While `ale` is 1, `addr` equals `{ahs_in, ad_in}` combinationally.
- R2: While `ale` is 0, `addr` holds the value of `{ahs_in, ad_in}` sampled at the last rising clock edge at which `ale` was 1, unchanged across wait states.
- R3: At the first rising edge that samples `ale` low after an edge that sampled it high, the block registers the status nibble from `ahs_in` and sets `stat_valid`. The bit order is `ahs_in[3]`=S6, `[2]`=S5, `[1]`=S4 and `[0]`=S3. `int_en` = S5 and `seg_sel` = {S4,S3}, encoded as 00 extra, 01 stack, 10 code or none, 11 data.
- R4: `proto_err` is set at the capture edge when S6 is sampled as 1, and is 0 otherwise. Every rising edge that samples `ale` high clears both `proto_err` and `stat_valid`.
- R5: `ad_oe` is 1 exactly when `rd_n` is 0 and `ale` is 0. `ad_out` equals `dev_rdata` when `ad_oe` is 1 and is 0 otherwise, so a read strobe during the address phase drives nothing.
- R6: After the first data-phase edge, each rising edge in the data phase that samples `dev_ready` low makes `cpu_ready` 0 from that edge on, and an edge that samples it high restores 1. The first edge after the address phase ignores `dev_ready` and gives `cpu_ready` 1.
- R7: After reset, with `ale` low, `addr` is 0, `seg_sel`, `int_en`, `stat_valid` and `proto_err` are 0, and `cpu_ready` is 1.
- R8: `seg_sel` and `int_en` stay unchanged from the capture edge until the next capture edge, whatever `ahs_in` does in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address-latch strobe from the processor |
| ad_in | input | 16 | Low shared lines as seen from the bus |
| ahs_in | input | 4 | Upper shared lines: address high bits, then status |
| rd_n | input | 1 | Read strobe, active low |
| dev_rdata | input | 16 | Read data from the selected memory or I/O device |
| dev_ready | input | 1 | Device ready; 0 requests a wait state |
| addr | output | 20 | Demultiplexed address |
| ad_out | output | 16 | Read data to drive onto the low shared lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| seg_sel | output | 2 | Decoded segment of the current cycle |
| int_en | output | 1 | Captured interrupt-enable state |
| stat_valid | output | 1 | Status captured for the current cycle |
| proto_err | output | 1 | Status bit S6 was sampled as 1 |
| cpu_ready | output | 1 | Ready toward the processor; 0 during a wait state |

## Verification
`addr`, `ad_oe` and `ad_out` have no register on the path from their inputs, so they are due in the same cycle as the stimulus. The status outputs, `proto_err` and `cpu_ready` each pass through one register and are due one edge after the inputs are sampled. The bench drives inputs on the falling edge and advances its own model at each rising edge with the values held there. It compares every output a quarter period later, when both the combinational and the registered results have settled. Bus cycles with a multi-cycle strobe, a read strobe during the address phase, garbage on the low lines during the data phase and several wait-state counts cover the hold and timing corners.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_WAIT
  } phase_e;

  typedef struct packed {
    logic s6;
    logic s5;
    seg_e seg;
  } stat_t;

  // Split the status nibble carried on the upper lines after the address phase.
  function automatic stat_t unpack_status(input logic [3:0] nib);
    stat_t s;
    s.s6  = nib[3];
    s.s5  = nib[2];
    s.seg = seg_e'(nib[1:0]);
    return s;
  endfunction

  // S6 is defined as constant zero; a one indicates a broken bus cycle.
  function automatic logic status_bad(input stat_t s);
    return s.s6;
  endfunction

endpackage

// File: rtl/adbus_addr_latch.sv
module adbus_addr_latch #(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic [LO_W-1:0]      lo,
  input  logic [HI_W-1:0]      hi,
  output logic [LO_W+HI_W-1:0] addr
);
  localparam int W = LO_W + HI_W;

  logic [W-1:0] live;
  logic [W-1:0] held_q;

  assign live = {hi, lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (ale) held_q <= live;
  end

  assign addr = ale ? live : held_q;
endmodule

// File: rtl/adbus_status_cap.sv
module adbus_status_cap
  import adbus_pkg::*;
#(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [HI_W-1:0] hi,
  output logic            cap_evt,
  output logic [1:0]      seg_sel,
  output logic            int_en,
  output logic            stat_valid,
  output logic            proto_err
);
  logic  ale_d_q;
  seg_e  seg_q;
  logic  ie_q;
  logic  valid_q;
  logic  err_q;
  stat_t now_stat;

  assign now_stat = unpack_status(hi[3:0]);
  assign cap_evt  = ale_d_q & ~ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d_q <= 1'b0;
      seg_q   <= SEG_EXTRA;
      ie_q    <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ale_d_q <= ale;
      if (ale) begin
        valid_q <= 1'b0;
        err_q   <= 1'b0;
      end else if (cap_evt) begin
        seg_q   <= now_stat.seg;
        ie_q    <= now_stat.s5;
        valid_q <= 1'b1;
        err_q   <= status_bad(now_stat);
      end
    end
  end

  assign seg_sel    = seg_q;
  assign int_en     = ie_q;
  assign stat_valid = valid_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/adbus_rd_drive.sv
module adbus_rd_drive #(
  parameter int LO_W = 16
) (
  input  logic            ale,
  input  logic            rd_n,
  input  logic [LO_W-1:0] dev_rdata,
  output logic            ad_oe,
  output logic [LO_W-1:0] ad_out
);
  // Never drive while the processor still owns the lines for the address.
  assign ad_oe  = ~rd_n & ~ale;
  assign ad_out = ad_oe ? dev_rdata : '0;
endmodule

// File: rtl/adbus_wait_fsm.sv
module adbus_wait_fsm
  import adbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic dev_ready,
  output logic in_wait,
  output logic cpu_ready
);
  phase_e ph_q;
  phase_e ph_nx;

  always_comb begin
    ph_nx = ph_q;
    if (ale) begin
      ph_nx = PH_ADDR;
    end else begin
      unique case (ph_q)
        PH_IDLE:          ph_nx = PH_IDLE;
        PH_ADDR:          ph_nx = PH_DATA;
        PH_DATA, PH_WAIT: ph_nx = dev_ready ? PH_DATA : PH_WAIT;
        default:          ph_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_nx;
  end

  assign in_wait   = (ph_q == PH_WAIT);
  assign cpu_ready = ~in_wait;
endmodule

// File: rtl/adbus_demux.sv
module adbus_demux
  import adbus_pkg::*;
#(
  parameter int ADDR_LO_W = 16,
  parameter int ADDR_HI_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ale,
  input  logic [ADDR_LO_W-1:0]           ad_in,
  input  logic [ADDR_HI_W-1:0]           ahs_in,
  input  logic                           rd_n,
  input  logic [ADDR_LO_W-1:0]           dev_rdata,
  input  logic                           dev_ready,
  output logic [ADDR_LO_W+ADDR_HI_W-1:0] addr,
  output logic [ADDR_LO_W-1:0]           ad_out,
  output logic                           ad_oe,
  output logic [1:0]                     seg_sel,
  output logic                           int_en,
  output logic                           stat_valid,
  output logic                           proto_err,
  output logic                           cpu_ready
);
  // Internal events brought out by name for the bound checker.
  logic cap_evt;
  logic in_wait;

  adbus_addr_latch #(.LO_W(ADDR_LO_W), .HI_W(ADDR_HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .lo(ad_in), .hi(ahs_in), .addr(addr)
  );

  adbus_status_cap #(.HI_W(ADDR_HI_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .ale(ale), .hi(ahs_in), .cap_evt(cap_evt),
    .seg_sel(seg_sel), .int_en(int_en), .stat_valid(stat_valid), .proto_err(proto_err)
  );

  adbus_rd_drive #(.LO_W(ADDR_LO_W)) u_rd (
    .ale(ale), .rd_n(rd_n), .dev_rdata(dev_rdata), .ad_oe(ad_oe), .ad_out(ad_out)
  );

  adbus_wait_fsm u_wait (
    .clk(clk), .rst_n(rst_n), .ale(ale), .dev_ready(dev_ready),
    .in_wait(in_wait), .cpu_ready(cpu_ready)
  );
endmodule

// File: rtl/adbus_demux_chk.sv
module adbus_demux_chk #(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ale,
  input logic [LO_W-1:0]      ad_in,
  input logic [HI_W-1:0]      ahs_in,
  input logic                 rd_n,
  input logic                 dev_ready,
  input logic [LO_W+HI_W-1:0] addr,
  input logic [LO_W-1:0]      ad_out,
  input logic                 ad_oe,
  input logic [1:0]           seg_sel,
  input logic                 int_en,
  input logic                 stat_valid,
  input logic                 proto_err,
  input logic                 cpu_ready,
  input logic                 cap_evt,
  input logic                 in_wait
);
  // R1
  addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (addr == {ahs_in, ad_in}));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(addr));

  // R3
  stat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ale) && $past(ale, 2)) |-> (stat_valid && int_en == $past(ahs_in[2])
                                        && seg_sel == $past(ahs_in[1:0])));

  // R3
  cap_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> stat_valid);

  // R4
  err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> stat_valid);

  // R4
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ale) |-> (!stat_valid && !proto_err));

  // R5
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || ale) |-> (!ad_oe && ad_out == '0));

  // R6
  wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (!$past(dev_ready) && in_wait));

  // R8
  stat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ale) && !$past(ale, 2)) |-> ($stable(seg_sel) && $stable(int_en)));
endmodule

bind adbus_demux adbus_demux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .ahs_in(ahs_in),
  .rd_n(rd_n), .dev_ready(dev_ready), .addr(addr), .ad_out(ad_out),
  .ad_oe(ad_oe), .seg_sel(seg_sel), .int_en(int_en), .stat_valid(stat_valid),
  .proto_err(proto_err), .cpu_ready(cpu_ready), .cap_evt(cap_evt), .in_wait(in_wait)
);

// File: tb/adbus_demux_test.sv
module adbus_demux_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [15:0] ad_in = '0;
  logic [3:0]  ahs_in = '0;
  logic        rd_n = 1'b1;
  logic [15:0] dev_rdata = '0;
  logic        dev_ready = 1'b1;
  logic [19:0] addr;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [1:0]  seg_sel;
  logic        int_en;
  logic        stat_valid;
  logic        proto_err;
  logic        cpu_ready;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  bit finished = 1'b0;

  adbus_demux uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .ahs_in(ahs_in),
    .rd_n(rd_n), .dev_rdata(dev_rdata), .dev_ready(dev_ready), .addr(addr),
    .ad_out(ad_out), .ad_oe(ad_oe), .seg_sel(seg_sel), .int_en(int_en),
    .stat_valid(stat_valid), .proto_err(proto_err), .cpu_ready(cpu_ready)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: a history of sampled strobe values and plain integers.
  int  m_addr, m_seg, m_ie, m_valid, m_err, m_waiting, m_stage;
  bit  m_captured;
  bit  ale_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_seg = 0; m_ie = 0; m_valid = 0; m_err = 0;
      m_waiting = 0; m_stage = 0; m_captured = 0;
      ale_hist.delete();
      ale_hist.push_back(1'b0);
    end else begin
      m_captured = 0;
      if (ale) begin
        m_addr = {ahs_in, ad_in};
        m_valid = 0; m_err = 0; m_waiting = 0; m_stage = 1;
      end else begin
        if (ale_hist[$]) begin
          m_seg = ahs_in[1:0]; m_ie = ahs_in[2]; m_err = ahs_in[3];
          m_valid = 1; m_captured = 1;
        end
        if (m_stage == 1) begin
          m_stage = 2; m_waiting = 0;
        end else if (m_stage == 2) begin
          m_waiting = dev_ready ? 0 : 1;
        end
      end
      ale_hist.push_back(ale);
      if (ale_hist.size() > 4) void'(ale_hist.pop_front());
    end
    #(PERIOD/4);
    if (armed) begin
      chk(ale ? "R1" : "R2", "addr", addr, ale ? {ahs_in, ad_in} : m_addr);
      chk(m_captured ? "R3" : "R8", "seg_sel", seg_sel, m_seg);
      chk(m_captured ? "R3" : "R8", "int_en", int_en, m_ie);
      chk("R3", "stat_valid", stat_valid, m_valid);
      chk("R4", "proto_err", proto_err, m_err);
      chk("R5", "ad_oe", ad_oe, (!rd_n && !ale) ? 1 : 0);
      chk("R5", "ad_out", ad_out, (!rd_n && !ale) ? dev_rdata : 0);
      chk("R6", "cpu_ready", cpu_ready, m_waiting ? 0 : 1);
    end
  end

  task automatic bus_cycle(input logic [19:0] a, input logic [3:0] st, input bit rd,
                           input logic [15:0] d, input int waits, input int ale_len,
                           input bit rd_in_ale, input bit first_ready);
    for (int i = 0; i < ale_len; i++) begin
      @(negedge clk);
      ale = 1'b1;
      {ahs_in, ad_in} = a + 20'(i);
      rd_n = rd_in_ale ? 1'b0 : 1'b1;
      dev_rdata = d;
      dev_ready = 1'b1;
    end
    @(negedge clk);
    ale = 1'b0;
    ahs_in = st;
    ad_in = ~a[15:0];
    rd_n = !rd;
    dev_ready = first_ready;
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      dev_ready = 1'b0;
      ahs_in = ~st;
    end
    @(negedge clk);
    dev_ready = 1'b1;
    @(negedge clk);
    rd_n = 1'b1;
    ad_in = 16'h0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    armed = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state seen at the ports
    chk("R7", "addr", addr, 0);
    chk("R7", "seg_sel", seg_sel, 0);
    chk("R7", "int_en", int_en, 0);
    chk("R7", "stat_valid", stat_valid, 0);
    chk("R7", "proto_err", proto_err, 0);
    chk("R7", "cpu_ready", cpu_ready, 1);
    repeat (2) @(negedge clk);

    bus_cycle(20'hA1234, 4'b0100, 1'b1, 16'hBEEF, 0, 1, 1'b0, 1'b1);
    bus_cycle(20'h58001, 4'b0001, 1'b1, 16'h1357, 3, 1, 1'b0, 1'b0);
    bus_cycle(20'hFFFF0, 4'b0010, 1'b0, 16'h0000, 1, 1, 1'b0, 1'b1);
    bus_cycle(20'h00007, 4'b1011, 1'b1, 16'hC0DE, 2, 1, 1'b0, 1'b1);
    bus_cycle(20'h3FFFE, 4'b0111, 1'b1, 16'h55AA, 4, 3, 1'b1, 1'b0);
    bus_cycle(20'h80000, 4'b1100, 1'b0, 16'hFFFF, 0, 2, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++)
      bus_cycle(20'(k * 20'h1F3D7 + 20'h00321), 4'(k), k[0], 16'(k * 16'h2B1),
                k % 4, 1 + (k % 2), k[1], k[2]);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule